// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Word Memory

This block is a single-port synchronous store of 32-bit words that a processor-style master reaches with byte addresses. Each request presents a byte address, a direction bit, a transfer size (one byte or a full word) and write data. Bits above the two lowest address bits pick the word. The two lowest bits pick a byte within that word, counted big-endian: offset zero is the most significant byte.

A byte write changes only the addressed byte, and the other three bytes of that word keep their contents. A read always returns the whole word, whichever size was requested. A full-word request whose address is not a multiple of four is refused: it raises an error pulse and leaves the store untouched. Every response appears on registered outputs one clock after the request. The master issues at most one request per cycle and never waits.

Top module: `bemem_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rvalid_o`, `err_o` and `rdata_o` are all zero.
- R2: The word is selected by address bits [log2(DEPTH)+1:2]. Address bits above those are ignored, so addresses that differ only in those bits reach the same word.
- R3: A full-word write (`size_i`=1) to an address with bits [1:0]=0 stores all 32 bits of `wdata_i`. In the following cycle `rvalid_o` and `err_o` are both 0.
- R4: A byte write (`size_i`=0) stores `wdata_i[7:0]` in the lane chosen by address bits [1:0]. Offset 0 maps to bits 31:24, offset 1 to 23:16, offset 2 to 15:8 and offset 3 to 7:0.
- R5: A byte write leaves the other three bytes of the addressed word unchanged.
- R6: A legal read (`we_i`=0, any byte offset, or a word at an aligned address) gives `rvalid_o`=1 in the next cycle, with `rdata_o` holding the whole stored word.
- R7: A full-word request, read or write, with address bits [1:0] nonzero gives `err_o`=1 and `rvalid_o`=0 in the next cycle and changes no stored data.
- R8: In a cycle with `req_i`=0, the next cycle shows `rvalid_o`=0 and `err_o`=0. `rdata_o` keeps its value in every cycle that does not carry a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response registers |
| req_i | input | 1 | Request strobe, one transfer per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 1 = full word, 0 = single byte |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 32 | Registered whole-word read data |
| rvalid_o | output | 1 | Read response valid, one cycle after the request |
| err_o | output | 1 | Misaligned full-word request flag, one cycle after the request |

## Verification
Every word is first filled with a distinct full-word pattern. After that, byte writes that land in a word already holding known data show both the lane mapping and whether the neighbouring bytes survive. A random mix of reads and writes of both sizes, with random upper address bits, separates correct big-endian steering from little-endian steering, and a correct word index from one that uses the wrong address bits. Directed cases cover the following:
- each of the four byte offsets within one word;
- misaligned full-word reads and writes, each followed by a read that shows nothing changed;
- addresses that differ only above the index;
- idle cycles, during which the read data must hold.

// File: rtl/bemem_pkg.sv
package bemem_pkg;
    localparam int LANE_BITS = 8;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } xfer_size_e;
endpackage

// File: rtl/bemem_lane_dec.sv
module bemem_lane_dec
    import bemem_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFFW = $clog2(LANES),
    localparam int DW   = LANES * LANE_BITS
) (
    input  logic             req,
    input  logic             we,
    input  xfer_size_e       size,
    input  logic [OFFW-1:0]  offset,
    input  logic [DW-1:0]    wdata,
    output logic             misalign,
    output logic [LANES-1:0] lane_we,
    output logic [DW-1:0]    lane_wdata
);
    logic             wr_go;
    logic [LANES-1:0] byte_sel;

    assign misalign = req && (size == SZ_WORD) && (offset != '0);
    assign wr_go    = req && we && !misalign;

    // Lane enable bit k belongs to byte offset k (offset 0 = most significant byte)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = (LANES - 1 - k) * LANE_BITS;
        assign byte_sel[k] = (offset == OFFW'(k));
        assign lane_we[k]  = wr_go && ((size == SZ_WORD) || byte_sel[k]);
        assign lane_wdata[LO +: LANE_BITS] =
            (size == SZ_WORD) ? wdata[LO +: LANE_BITS] : wdata[LANE_BITS-1:0];
    end
endmodule

// File: rtl/bemem_store.sv
module bemem_store
    import bemem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int IDXW = $clog2(DEPTH),
    localparam int DW   = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic [IDXW-1:0]  idx,
    input  logic [LANES-1:0] lane_we,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rword
);
    for (genvar k = 0; k < LANES; k++) begin : g_bank
        localparam int LO = (LANES - 1 - k) * LANE_BITS;
        logic [LANE_BITS-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[k]) begin
                bank[idx] <= wdata[LO +: LANE_BITS];
            end
        end

        assign rword[LO +: LANE_BITS] = bank[idx];
    end
endmodule

// File: rtl/bemem_top.sv
module bemem_top
    import bemem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 32,
    localparam int LANES = 4,
    localparam int DW    = LANES * LANE_BITS,
    localparam int OFFW  = $clog2(LANES),
    localparam int IDXW  = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic          size_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic          err_o
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } resp_t;

    resp_t            resp_d, resp_q;
    xfer_size_e       size;
    logic             misalign;
    logic [LANES-1:0] lane_we;
    logic [DW-1:0]    lane_wdata;
    logic [DW-1:0]    rword;
    logic [IDXW-1:0]  widx;

    assign size = xfer_size_e'(size_i);
    assign widx = addr_i[OFFW +: IDXW];

    bemem_lane_dec #(.LANES(LANES)) u_dec (
        .req        (req_i),
        .we         (we_i),
        .size       (size),
        .offset     (addr_i[OFFW-1:0]),
        .wdata      (wdata_i),
        .misalign   (misalign),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    bemem_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
        .clk     (clk),
        .idx     (widx),
        .lane_we (lane_we),
        .wdata   (lane_wdata),
        .rword   (rword)
    );

    always_comb begin
        resp_d        = resp_q;
        resp_d.rvalid = 1'b0;
        resp_d.err    = 1'b0;
        if (req_i) begin
            if (misalign) begin
                resp_d.err = 1'b1;
            end else if (!we_i) begin
                resp_d.rvalid = 1'b1;
                resp_d.rdata  = rword;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rdata_o  = resp_q.rdata;
    assign rvalid_o = resp_q.rvalid;
    assign err_o    = resp_q.err;
endmodule

// File: rtl/bemem_chk.sv
module bemem_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             we_i,
    input logic             size_i,
    input logic [1:0]       off,
    input logic [31:0]      rdata_o,
    input logic             rvalid_o,
    input logic             err_o,
    input logic [LANES-1:0] lane_we
);
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid_o && err_o)); // R7

    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i && (off != 2'b00)) |=> (err_o && !rvalid_o)); // R7

    AST_MISALIGN_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i && (off != 2'b00)) |-> (lane_we == '0)); // R7

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && !(size_i && (off != 2'b00))) |=> (rvalid_o && !err_o)); // R6

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i) |=> !rvalid_o); // R3

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && !size_i) |-> $onehot(lane_we)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!rvalid_o && !err_o)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> $stable(rdata_o)); // R8
endmodule

bind bemem_top bemem_chk #(.LANES(4)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .we_i     (we_i),
    .size_i   (size_i),
    .off      (addr_i[1:0]),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .err_o    (err_o),
    .lane_we  (lane_we)
);

// File: tb/bemem_top_bench.sv
`timescale 1ns/1ps
module bemem_top_bench;
    localparam int DEPTH = 256;
    localparam int IDXW  = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic        size_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rvalid_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [DEPTH];
    logic [31:0] last_rdata = '0;

    always #10 clk = ~clk;

    bemem_top #(.DEPTH(DEPTH)) u_bemem_top (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .err_o(err_o)
    );

    function automatic logic [31:0] exp_after_write(input logic [31:0] old,
            input logic sz, input logic [1:0] off, input logic [31:0] wd);
        logic [31:0] w;
        w = old;
        if (sz) w = wd;
        else w[(3 - off) * 8 +: 8] = wd[7:0];
        return w;
    endfunction

    function automatic logic is_misaligned(input logic sz, input logic [31:0] a);
        return sz && (a[1:0] != 2'b00);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives a request, checks the response one negedge later
    task automatic access(input logic we, input logic sz, input logic [31:0] a,
                          input logic [31:0] wd, input string tag);
        int idx;
        logic bad;
        idx = int'(a[IDXW+1:2]);
        bad = is_misaligned(sz, a);
        req_i = 1'b1; we_i = we; size_i = sz; addr_i = a; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        if (bad) begin
            check({tag, " R7 err"}, 32'(err_o), 32'd1);
            check({tag, " R7 rvalid"}, 32'(rvalid_o), 32'd0);
            check({tag, " R8 rdata hold"}, rdata_o, last_rdata);
        end else if (we) begin
            check({tag, " R3 quiet"}, {30'd0, rvalid_o, err_o}, 32'd0);
            check({tag, " R8 rdata hold"}, rdata_o, last_rdata);
            model[idx] = exp_after_write(model[idx], sz, a[1:0], wd);
        end else begin
            check({tag, " R6 rvalid"}, {30'd0, rvalid_o, err_o}, 32'd2);
            check({tag, " R6 rdata"}, rdata_o, model[idx]);
            last_rdata = model[idx];
        end
    endtask

    task automatic idle(input string tag);
        req_i = 1'b0;
        @(negedge clk);
        check({tag, " R8 idle flags"}, {30'd0, rvalid_o, err_o}, 32'd0);
        check({tag, " R8 idle hold"}, rdata_o, last_rdata);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset flags", {30'd0, rvalid_o, err_o}, 32'd0);
        check("R1 reset rdata", rdata_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {rdata_o[29:0], rvalid_o, err_o}, 32'd0);

        // Fill every word (R3)
        for (int i = 0; i < DEPTH; i++) begin
            access(1'b1, 1'b1, 32'(i) << 2, 32'hA5000000 ^ (32'(i) * 32'h01030507), "fill R3");
        end

        // Lane mapping on a known word (R4, R5)
        access(1'b1, 1'b1, 32'h40, 32'h11223344, "R3 dir");
        access(1'b1, 1'b0, 32'h40, 32'hFFFFFFAA, "R4 off0");
        access(1'b0, 1'b1, 32'h40, 32'h0, "R5 read");
        check("R4 offset0 to bits31:24", rdata_o, 32'hAA223344);
        access(1'b1, 1'b0, 32'h41, 32'h000000BB, "R4 off1");
        access(1'b1, 1'b0, 32'h42, 32'h000000CC, "R4 off2");
        access(1'b1, 1'b0, 32'h43, 32'h000000DD, "R4 off3");
        access(1'b0, 1'b0, 32'h42, 32'h0, "R6 byte read");
        check("R4 all lanes", rdata_o, 32'hAABBCCDD);
        access(1'b1, 1'b0, 32'h45, 32'h0000007E, "R5 neigh");
        access(1'b0, 1'b1, 32'h44, 32'h0, "R5 neigh read");
        access(1'b0, 1'b1, 32'h40, 32'h0, "R5 untouched");

        // Misaligned word accesses (R7)
        access(1'b1, 1'b1, 32'h81, 32'hDEADBEEF, "R7 wr1");
        access(1'b1, 1'b1, 32'h82, 32'hDEADBEEF, "R7 wr2");
        access(1'b1, 1'b1, 32'h83, 32'hDEADBEEF, "R7 wr3");
        access(1'b0, 1'b1, 32'h82, 32'h0, "R7 rd");
        access(1'b0, 1'b1, 32'h80, 32'h0, "R7 unchanged");

        // Aliasing through upper address bits (R2)
        access(1'b1, 1'b1, 32'hFFFF_F010, 32'h0BADF00D, "R2 wr high");
        access(1'b0, 1'b1, 32'h0000_0010, 32'h0, "R2 rd low");
        check("R2 alias", rdata_o, 32'h0BADF00D);

        idle("R8 a");
        idle("R8 b");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            logic        we, sz;
            int          pick;
            a    = $urandom();
            pick = int'($urandom_range(0, 9));
            we   = (pick < 5);
            sz   = $urandom_range(0, 1) == 1;
            if (sz && $urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            if (pick == 9) idle("R8 rnd");
            else access(we, sz, a, $urandom(), "rnd");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule